// File: doc/BRIEF.md
# Dual-Channel Master Serial Readout Controller

This block sends the two 16-bit results of a dual-channel conversion out of the chip on a serial link. The block generates the serial clock itself. Each frame carries channel A and then channel B, most significant bit first, on `sdout`. The `sclk` output toggles with a 50% duty cycle, and the `sync` output is high while a channel's bits are valid. The converter is modelled by two pulses. `conv_start` opens a conversion. `conv_done` closes it and presents the two result words on `res_a` and `res_b`.

A mode input picks one of two schedules. In after-conversion mode, the words that arrive with `conv_done` are shifted out at once, and `busy` stays high until the last bit has gone. This mode also honours a clock divider for slow hosts. In during-conversion mode, each new `conv_start` shifts out the words captured by the previous conversion while the new conversion runs, and `busy` covers only the conversion. The polarity of `sclk` and of `sync` can each be inverted. A sticky flag records start requests that arrive while a frame is running; those requests are otherwise ignored.

Top module: `dual_word_serial_master`

## Requirements
- R1: After reset `busy`, `overrun`, `sdout` are 0 and the raw (non-inverted) `sclk` and `sync` levels are 0.
- R2: A frame is exactly 32 rising raw `sclk` edges; the bit presented at the k-th rising edge is `res_a[15-k]` for k<16, then `res_b[31-k]`.
- R3: Raw `sclk` has a 50% duty cycle with a period of 4×2^`div_sel` clock cycles; the first rising edge comes 2^`div_sel` cycles after the frame begins, and raw `sclk` is 0 outside frames.
- R4: Raw `sync` is high on every rising raw `sclk` edge of a frame, and falls exactly twice per frame: after the falling edge that follows bit 0 of channel A and after the one that follows bit 0 of channel B.
- R5: `sdout` never changes in a cycle where raw `sclk` changes, so it is valid on both edges.
- R6: `inv_sclk`=1 inverts `sclk` and `inv_sync`=1 inverts `sync`, independently; with both set, the idle pin levels are 1.
- R7: With `read_after`=1, `busy` rises the cycle after `conv_start` and stays high through the frame, falling 128×2^`div_sel` cycles after the frame starts on `conv_done`.
- R8: `div_sel` (ratio 2^`div_sel`: 1, 2, 4, 8) is applied in after-conversion mode and is latched when a frame starts.
- R9: With `read_after`=0, a `conv_start` shifts out the words captured by the preceding conversion; the first conversion after reset produces no frame; the divider is ignored (ratio 1); a `conv_done` during a frame does not disturb the frame in flight.
- R10: With `read_after`=0, `busy` is high only from `conv_start` to `conv_done`, even while the frame is still shifting.
- R11: A `conv_start` sampled while a frame is active, including the frame's final cycle, is ignored and sets `overrun`, which stays set until reset; a start one cycle after the frame ends is accepted.
- R12: With `ext_clk_sel`=1, no frame is generated: raw `sclk` stays 0 and `busy` falls the cycle after `conv_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk_sel | input | 1 | 1 disables internal clock generation and frames |
| read_after | input | 1 | 1 = shift after conversion, 0 = during the next conversion |
| inv_sclk | input | 1 | Invert the serial clock pin |
| inv_sync | input | 1 | Invert the framing pin |
| div_sel | input | 2 | Clock divide ratio 2^div_sel (after-conversion mode) |
| conv_start | input | 1 | Conversion start pulse |
| conv_done | input | 1 | Conversion complete pulse, qualifies res_a/res_b |
| res_a | input | 16 | Channel A result |
| res_b | input | 16 | Channel B result |
| busy | output | 1 | Conversion (and, in after mode, readout) in progress |
| sclk | output | 1 | Serial clock |
| sdout | output | 1 | Serial data |
| sync | output | 1 | Frame-valid marker |
| overrun | output | 1 | Sticky ignored-start flag |

## Verification
Two events can share a cycle. The first is a `conv_done` that refills the holding words while a during-conversion frame is still shifting the older words. The second is a `conv_start` that lands on the final cycle of a frame. The first case is provoked by ending a conversion partway through the frame. The bench then checks that the current frame carries the old words and that the next frame carries the new ones. The second case is provoked by driving the start so that it is sampled on the frame's last edge, which must set `overrun` and leave `busy` low. A start one cycle later must be accepted and must produce a full frame.

// File: rtl/dual_word_serial_master.sv
module dual_word_serial_master #(
  parameter int WORD_W = 16,
  parameter int DIV_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_clk_sel,
  input  logic              read_after,
  input  logic              inv_sclk,
  input  logic              inv_sync,
  input  logic [DIV_W-1:0]  div_sel,
  input  logic              conv_start,
  input  logic              conv_done,
  input  logic [WORD_W-1:0] res_a,
  input  logic [WORD_W-1:0] res_b,
  output logic              busy,
  output logic              sclk,
  output logic              sdout,
  output logic              sync,
  output logic              overrun
);
  localparam int FRAME_BITS = 2 * WORD_W;
  localparam int BIT_CW     = $clog2(FRAME_BITS);
  localparam int LOW_W      = $clog2(WORD_W);
  localparam int MAX_R      = 1 << ((1 << DIV_W) - 1);
  localparam int Q_W        = $clog2(4 * MAX_R) + 1;

  logic                  converting, conv_after;
  logic                  frame_active, frame_after;
  logic [Q_W-1:0]        q, quarter;
  logic [BIT_CW-1:0]     bit_idx;
  logic [FRAME_BITS-1:0] shreg, hold;
  logic                  hold_valid;

  logic [Q_W-1:0] r_sel, last_q, three_q;
  logic start_ok, conv_end, launch_after, launch_during, raw_sclk, raw_sync, lsb_tail;

  assign r_sel    = Q_W'(1) << div_sel;
  assign last_q   = (quarter << 2) - Q_W'(1);
  assign three_q  = (quarter << 1) + quarter;

  assign start_ok      = conv_start && !converting && !frame_active;
  assign conv_end      = conv_done && converting;
  assign launch_after  = conv_end && conv_after && !ext_clk_sel;
  assign launch_during = start_ok && !read_after && hold_valid && !ext_clk_sel;

  assign raw_sclk = frame_active && (q >= quarter) && (q < three_q);
  assign lsb_tail = (bit_idx[LOW_W-1:0] == LOW_W'(WORD_W - 1)) && (q >= three_q);
  assign raw_sync = frame_active && !lsb_tail;

  assign sclk  = raw_sclk ^ inv_sclk;
  assign sync  = raw_sync ^ inv_sync;
  assign sdout = frame_active & shreg[FRAME_BITS-1];
  assign busy  = converting | (frame_active & frame_after);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      converting   <= 1'b0;
      conv_after   <= 1'b0;
      frame_active <= 1'b0;
      frame_after  <= 1'b0;
      q            <= '0;
      quarter      <= Q_W'(1);
      bit_idx      <= '0;
      shreg        <= '0;
      hold         <= '0;
      hold_valid   <= 1'b0;
      overrun      <= 1'b0;
    end else begin
      if (start_ok) begin
        converting <= 1'b1;
        conv_after <= read_after;
      end else if (conv_end) begin
        converting <= 1'b0;
      end

      if (conv_start && frame_active)
        overrun <= 1'b1;

      if (conv_end && !conv_after) begin
        hold       <= {res_a, res_b};
        hold_valid <= 1'b1;
      end else if (launch_during) begin
        hold_valid <= 1'b0;
      end

      if (launch_after || launch_during) begin
        frame_active <= 1'b1;
        frame_after  <= launch_after;
        shreg        <= launch_after ? {res_a, res_b} : hold;
        quarter      <= launch_after ? r_sel : Q_W'(1);
        q            <= '0;
        bit_idx      <= '0;
      end else if (frame_active) begin
        if (q == last_q) begin
          q       <= '0;
          shreg   <= shreg << 1;
          bit_idx <= bit_idx + BIT_CW'(1);
          if (bit_idx == BIT_CW'(FRAME_BITS - 1))
            frame_active <= 1'b0;
        end else begin
          q <= q + Q_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/dual_word_serial_master_chk.sv
module dual_word_serial_master_chk (
  input logic clk,
  input logic rst_n,
  input logic inv_sclk,
  input logic inv_sync,
  input logic sclk,
  input logic sync,
  input logic sdout,
  input logic busy,
  input logic overrun,
  input logic frame_active,
  input logic frame_after
);
  a_r5_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk ^ inv_sclk) |-> $stable(sdout));

  a_r5_stable_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk ^ inv_sclk) |-> $stable(sdout));

  a_r3_quiet_clock_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_active |-> !(sclk ^ inv_sclk));

  a_r4_sync_within_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (sync ^ inv_sync) |-> frame_active);

  a_r7_busy_holds_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_active && frame_after) |-> busy);

  a_r11_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

bind dual_word_serial_master dual_word_serial_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .inv_sclk(inv_sclk), .inv_sync(inv_sync),
  .sclk(sclk), .sync(sync), .sdout(sdout), .busy(busy), .overrun(overrun),
  .frame_active(frame_active), .frame_after(frame_after)
);

// File: tb/dual_word_serial_master_tb_top.sv
module dual_word_serial_master_tb_top;
  logic clk = 1'b0;
  logic rst_n, ext_clk_sel, read_after, inv_sclk, inv_sync, conv_start, conv_done;
  logic [1:0]  div_sel;
  logic [15:0] res_a, res_b;
  logic busy, sclk, sdout, sync, overrun;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dual_word_serial_master dut_i (
    .clk(clk), .rst_n(rst_n), .ext_clk_sel(ext_clk_sel), .read_after(read_after),
    .inv_sclk(inv_sclk), .inv_sync(inv_sync), .div_sel(div_sel),
    .conv_start(conv_start), .conv_done(conv_done), .res_a(res_a), .res_b(res_b),
    .busy(busy), .sclk(sclk), .sdout(sdout), .sync(sync), .overrun(overrun)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ext_clk_sel = 1'b0; read_after = 1'b1; inv_sclk = 1'b0;
    inv_sync = 1'b0; div_sel = 2'd0; conv_start = 1'b0; conv_done = 1'b0;
    res_a = '0; res_b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    conv_start = 1'b1;
    @(negedge clk);
    conv_start = 1'b0;
  endtask

  task automatic pulse_done(input logic [15:0] a, input logic [15:0] b);
    res_a = a; res_b = b; conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic collect(input int ncyc, input int start_at, input int done_at,
                         input logic [15:0] da, input logic [15:0] db, input int probe_at,
                         output logic [31:0] word, output int rises, output int sfalls,
                         output int unstable, output int nosync, output logic busy_probe,
                         output int first_rise);
    logic prev_raw, prev_sync, prev_sd, raw, sr;
    word = '0; rises = 0; sfalls = 0; unstable = 0; nosync = 0;
    busy_probe = 1'bx; first_rise = -1;
    prev_raw = 1'b0; prev_sync = 1'b0; prev_sd = sdout;
    for (int i = 0; i < ncyc; i++) begin
      raw = sclk ^ inv_sclk;
      sr  = sync ^ inv_sync;
      if (i > 0 && raw != prev_raw && sdout != prev_sd) unstable++;
      if (raw && !prev_raw) begin
        rises++;
        word = {word[30:0], sdout};
        if (!sr) nosync++;
        if (first_rise < 0) first_rise = i;
      end
      if (!sr && prev_sync) sfalls++;
      if (i == probe_at) busy_probe = busy;
      prev_raw = raw; prev_sync = sr; prev_sd = sdout;
      conv_start = (i == start_at);
      conv_done  = (i == done_at);
      if (i == done_at) begin res_a = da; res_b = db; end
      @(negedge clk);
    end
    conv_start = 1'b0;
    conv_done  = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk(busy == 1'b0, "R1", "busy", busy, 0);
    chk(overrun == 1'b0, "R1", "overrun", overrun, 0);
    chk(sdout == 1'b0, "R1", "sdout", sdout, 0);
    chk(sclk == 1'b0 && sync == 1'b0, "R1", "sclk/sync", {sclk, sync}, 0);
  endtask

  task automatic t_after(input logic [1:0] dv, input logic iv,
                         input logic [15:0] a, input logic [15:0] b);
    logic [31:0] w; int r, sf, un, ns, fr; logic bp;
    int ratio = 1 << dv;
    do_reset();
    read_after = 1'b1; div_sel = dv; inv_sclk = iv; inv_sync = iv;
    @(negedge clk);
    if (iv) chk(sclk == 1'b1 && sync == 1'b1, "R6", "inverted idle pins", {sclk, sync}, 2'b11);
    pulse_start();
    chk(busy == 1'b1, "R7", "busy after start", busy, 1);
    repeat (3) @(negedge clk);
    pulse_done(a, b);
    collect(128 * ratio, -1, -1, '0, '0, 128 * ratio - 1, w, r, sf, un, ns, bp, fr);
    chk(w == {a, b}, "R2", "frame word", w, {a, b});
    chk(r == 32, "R2", "rising edges", r, 32);
    chk(fr == ratio, "R3", "first rise offset", fr, ratio);
    chk(sf == 2 && ns == 0, "R4", "sync falls / missing", {sf[15:0], ns[15:0]}, 32'h20000);
    chk(un == 0, "R5", "sdout changes on clock edge", un, 0);
    chk(bp == 1'b1, "R7", "busy at last frame cycle", bp, 1);
    chk(busy == 1'b0, "R7", "busy after frame", busy, 0);
    if (dv != 0) chk(fr == ratio, "R8", "divider ratio", fr, ratio);
    if (iv) chk(sclk == 1'b1 && sync == 1'b1, "R6", "inverted idle after frame", {sclk, sync}, 2'b11);
  endtask

  task automatic t_during();
    logic [31:0] w; int r, sf, un, ns, fr; logic bp;
    do_reset();
    read_after = 1'b0; div_sel = 2'd3;
    pulse_start();
    collect(20, -1, 3, 16'h1234, 16'hFEDC, 10, w, r, sf, un, ns, bp, fr);
    chk(r == 0, "R9", "first conversion frame edges", r, 0);
    chk(bp == 1'b0, "R10", "busy after done, no frame", bp, 0);
    pulse_start();
    chk(busy == 1'b1, "R10", "busy during conversion", busy, 1);
    collect(128, -1, 30, 16'h0F0F, 16'h8001, 33, w, r, sf, un, ns, bp, fr);
    chk(w == 32'h1234FEDC, "R9", "previous words shifted", w, 32'h1234FEDC);
    chk(fr == 1 && r == 32, "R9", "divider ignored first rise", fr, 1);
    chk(bp == 1'b0, "R10", "busy low while frame shifts", bp, 0);
    chk(un == 0, "R5", "sdout stability during mode", un, 0);
    pulse_start();
    collect(128, -1, 50, 16'hAAAA, 16'h5555, -1, w, r, sf, un, ns, bp, fr);
    chk(w == 32'h0F0F8001, "R9", "words captured mid-frame", w, 32'h0F0F8001);
  endtask

  task automatic t_overrun();
    logic [31:0] w; int r, sf, un, ns, fr; logic bp;
    do_reset();
    read_after = 1'b0;
    pulse_start();
    collect(10, -1, 2, 16'hC0DE, 16'h0BAD, -1, w, r, sf, un, ns, bp, fr);
    chk(overrun == 1'b0, "R11", "overrun before", overrun, 0);
    pulse_start();
    collect(128, 40, 60, 16'h1111, 16'h2222, -1, w, r, sf, un, ns, bp, fr);
    chk(w == 32'hC0DE0BAD && r == 32, "R11", "frame unaffected by ignored start", w, 32'hC0DE0BAD);
    chk(overrun == 1'b1, "R11", "overrun set mid-frame", overrun, 1);
    do_reset();
    read_after = 1'b0;
    pulse_start();
    collect(10, -1, 2, 16'hC0DE, 16'h0BAD, -1, w, r, sf, un, ns, bp, fr);
    pulse_start();
    collect(128, 127, 60, 16'h3C3C, 16'h7E81, -1, w, r, sf, un, ns, bp, fr);
    chk(overrun == 1'b1, "R11", "overrun on final frame cycle", overrun, 1);
    chk(busy == 1'b0, "R11", "start on final cycle ignored", busy, 0);
    pulse_start();
    chk(busy == 1'b1, "R11", "start one cycle later accepted", busy, 1);
    collect(128, -1, 70, 16'h0000, 16'h0000, -1, w, r, sf, un, ns, bp, fr);
    chk(w == 32'h3C3C7E81 && r == 32, "R11", "accepted start frame", w, 32'h3C3C7E81);
    chk(overrun == 1'b1, "R11", "overrun sticky", overrun, 1);
  endtask

  task automatic t_external();
    logic [31:0] w; int r, sf, un, ns, fr; logic bp;
    do_reset();
    ext_clk_sel = 1'b1; read_after = 1'b1;
    pulse_start();
    repeat (2) @(negedge clk);
    pulse_done(16'hFFFF, 16'hFFFF);
    chk(busy == 1'b0, "R12", "busy after done", busy, 0);
    collect(60, -1, -1, '0, '0, -1, w, r, sf, un, ns, bp, fr);
    chk(r == 0 && sclk == 1'b0, "R12", "no clock edges", r, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_after(2'd0, 1'b0, 16'hA5C3, 16'h1E7F);
    t_after(2'd2, 1'b0, 16'h8000, 16'h0001);
    t_after(2'd3, 1'b0, 16'h6DB6, 16'h4924);
    t_after(2'd1, 1'b1, 16'h9C31, 16'hE00F);
    t_during();
    t_overrun();
    t_external();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule